// File: doc/BRIEF.md
# Debounced switch input port

This block is a memory-mapped input device for a bank of toggle switches. It presents two registers on a shared address, write-enable and data bus. The data register holds a filtered copy of the switch levels. The control/status register carries three bits: a ready flag, an overrun flag and an interrupt enable. The raw switch lines first cross into the clock domain through a two-flop synchronizer. They then pass a stability filter, which accepts a new value only after the lines have held still for a programmable number of milliseconds.

Software polls the ready flag or takes the interrupt request, then reads the data register, and that read clears ready. If the filtered value changes again before software reads it, overrun records the loss. Overrun stays set until software writes a zero to it. When the device is not addressed, its read data output is all zeros. This lets many such devices be ORed onto one read bus.

Top module: `sw_port`

## Requirements
- R1: After reset the data register reads 0, the control register reads 0 and `irq` is low.
- R2: The data register (offset 0, switch value in bits NSW-1:0) takes a new switch value only after the synchronized input has stayed unchanged for STABLE_MS*CYC_PER_MS clock cycles. A shorter glitch leaves both the data register and the ready flag unchanged.
- R3: Ready, bit 0 of the control register (offset 4), becomes 1 whenever the filtered data value changes.
- R4: A read of the data register (address selected, `bus_we` low) clears ready. If a filtered change happens in the same cycle, ready stays set.
- R5: Overrun, bit 2 of the control register, becomes 1 when the filtered data changes while ready is already 1.
- R6: A control write with bit 2 at 0 clears overrun, and one with bit 2 at 1 leaves overrun unchanged. Bit 0 of a control write has no effect on ready.
- R7: Interrupt enable, bit 8 of the control register, is loaded by every control write and reads back. `irq` is high exactly when ready and interrupt enable are both 1.
- R8: Writes to the data register change neither the data register nor the flags.
- R9: `bus_rdata` is all zeros when neither register is addressed or when `bus_we` is high. Control bits other than 0, 2 and 8, and data bits above NSW-1, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | AW | Bus address |
| bus_we | input | 1 | Write enable; low means a read of the addressed register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, zero when not selected |
| sw_raw | input | NSW | Raw asynchronous switch levels |
| irq | output | 1 | Interrupt request |

## Verification
The bench sends a switch pulse shorter than the stability window. A filter that reacted at once would show the glitch in the data register and raise ready. It also samples the data register partway through a real change, which catches a window that is too short. The bench stacks a second change on an unread one to force overrun, then writes ones to the ready and overrun bits. A design that honoured those writes would show a spurious ready or a lost overrun. Writes to the data register, reads from an unused address and reads during a write are all checked. A device that drove the bus when not asked would corrupt the shared read bus with non-zero data.

// File: rtl/swp_pkg.sv
package swp_pkg;
    localparam int OFS_DATA = 0;
    localparam int OFS_CTRL = 4;
    localparam int BIT_RDY  = 0;
    localparam int BIT_OVR  = 2;
    localparam int BIT_IE   = 8;

    typedef struct packed {
        logic ready;
        logic ovr;
        logic ie;
    } ctrl_t;
endpackage

// File: rtl/swp_sync.sv
module swp_sync #(
    parameter int W      = 10,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] st_d [STAGES];
    logic [W-1:0] st_q [STAGES];

    always_comb begin
        st_d[0] = din;
        for (int i = 1; i < STAGES; i++) st_d[i] = st_q[i-1];
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) st_q[g] <= '0;
            else     st_q[g] <= st_d[g];
        end
    end

    assign dout = st_q[STAGES-1];
endmodule

// File: rtl/swp_debounce.sv
module swp_debounce #(
    parameter int W          = 10,
    parameter int CYC_PER_MS = 50000,
    parameter int STABLE_MS  = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         upd
);
    localparam int PW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam int MW = $clog2(STABLE_MS + 1);
    localparam logic [PW-1:0] PMAX = PW'(CYC_PER_MS - 1);
    localparam logic [MW-1:0] MSAT = MW'(STABLE_MS);

    typedef struct packed {
        logic [W-1:0]  last;
        logic [W-1:0]  deb;
        logic [PW-1:0] pres;
        logic [MW-1:0] ms;
    } dbs_t;

    dbs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        upd = 1'b0;
        if (din != r_q.last) begin
            r_d.last = din;
            r_d.pres = '0;
            r_d.ms   = '0;
        end else if (r_q.ms != MSAT) begin
            if (r_q.pres == PMAX) begin
                r_d.pres = '0;
                r_d.ms   = r_q.ms + 1'b1;
            end else begin
                r_d.pres = r_q.pres + 1'b1;
            end
        end else if (r_q.deb != r_q.last) begin
            r_d.deb = r_q.last;
            upd     = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.last <= '0;
            r_q.deb  <= '0;
            r_q.pres <= '0;
            r_q.ms   <= MSAT;
        end else begin
            r_q <= r_d;
        end
    end

    assign dout = r_q.deb;
endmodule

// File: rtl/sw_port.sv
module sw_port #(
    parameter int          NSW        = 10,
    parameter int          AW         = 32,
    parameter int          DW         = 32,
    parameter logic [31:0] BASE       = 32'h0000_0010,
    parameter int          CYC_PER_MS = 50000,
    parameter int          STABLE_MS  = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [NSW-1:0] sw_raw,
    output logic          irq
);
    import swp_pkg::*;

    localparam logic [AW-1:0] A_DATA = AW'(BASE + OFS_DATA);
    localparam logic [AW-1:0] A_CTRL = AW'(BASE + OFS_CTRL);

    logic [NSW-1:0] sw_sync;
    logic [NSW-1:0] deb;
    logic           deb_upd;
    logic           sel_data, sel_ctrl, rd_data, wr_ctrl;
    ctrl_t          ctl_d, ctl_q;
    logic           unused_wbits;

    swp_sync #(.W(NSW), .STAGES(2)) i_sync (
        .clk(clk), .rst(rst), .din(sw_raw), .dout(sw_sync)
    );

    swp_debounce #(.W(NSW), .CYC_PER_MS(CYC_PER_MS), .STABLE_MS(STABLE_MS)) i_deb (
        .clk(clk), .rst(rst), .din(sw_sync), .dout(deb), .upd(deb_upd)
    );

    assign sel_data = (bus_addr == A_DATA);
    assign sel_ctrl = (bus_addr == A_CTRL);
    assign rd_data  = sel_data && !bus_we;
    assign wr_ctrl  = sel_ctrl && bus_we;
    assign unused_wbits = ^bus_wdata;

    always_comb begin
        ctl_d = ctl_q;
        if (deb_upd)      ctl_d.ready = 1'b1;
        else if (rd_data) ctl_d.ready = 1'b0;

        if (deb_upd && ctl_q.ready)          ctl_d.ovr = 1'b1;
        else if (wr_ctrl && !bus_wdata[BIT_OVR]) ctl_d.ovr = 1'b0;

        if (wr_ctrl) ctl_d.ie = bus_wdata[BIT_IE];
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (!bus_we) begin
            if (sel_data) begin
                bus_rdata[NSW-1:0] = deb;
            end else if (sel_ctrl) begin
                bus_rdata[BIT_RDY] = ctl_q.ready;
                bus_rdata[BIT_OVR] = ctl_q.ovr;
                bus_rdata[BIT_IE]  = ctl_q.ie;
            end
        end
    end

    assign irq = ctl_q.ready && ctl_q.ie;
endmodule

// File: rtl/sw_port_chk.sv
module sw_port_chk #(
    parameter int NSW = 10,
    parameter int DW  = 32
) (
    input logic           clk,
    input logic           rst,
    input logic           bus_we,
    input logic [DW-1:0]  bus_wdata,
    input logic [DW-1:0]  bus_rdata,
    input logic           irq,
    input logic           sel_data,
    input logic           sel_ctrl,
    input logic           upd,
    input logic           ready_q,
    input logic           ovr_q,
    input logic           ie_q,
    input logic [NSW-1:0] deb
);
    assert_data_holds_R2: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(deb));

    assert_ready_sets_R3: assert property (@(posedge clk) disable iff (rst)
        upd |=> ready_q);

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (sel_data && !bus_we && !upd) |=> !ready_q);

    assert_overrun_sets_R5: assert property (@(posedge clk) disable iff (rst)
        (upd && ready_q) |=> ovr_q);

    assert_overrun_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        (sel_ctrl && bus_we && bus_wdata[2] && ovr_q) |=> ovr_q);

    assert_ie_loads_R7: assert property (@(posedge clk) disable iff (rst)
        (sel_ctrl && bus_we) |=> (ie_q == $past(bus_wdata[8])));

    assert_irq_off_R7: assert property (@(posedge clk) disable iff (rst)
        (sel_ctrl && bus_we && !bus_wdata[8]) |=> !irq);

    assert_quiet_on_write_R9: assert property (@(posedge clk) disable iff (rst)
        bus_we |-> (bus_rdata == '0));
endmodule

bind sw_port sw_port_chk #(.NSW(NSW), .DW(DW)) i_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .sel_data(sel_data), .sel_ctrl(sel_ctrl),
    .upd(deb_upd), .ready_q(ctl_q.ready), .ovr_q(ctl_q.ovr), .ie_q(ctl_q.ie),
    .deb(deb)
);

// File: tb/test_sw_port.sv
module test_sw_port;
    localparam int NSW = 10;
    localparam logic [31:0] BASE = 32'h0000_0010;
    localparam logic [31:0] A_DATA = BASE;
    localparam logic [31:0] A_CTRL = BASE + 4;
    localparam logic [31:0] A_OTHER = BASE + 8;
    localparam logic [31:0] A_IDLE = 32'h0000_0F00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] bus_addr = A_IDLE;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NSW-1:0] sw_raw = '0;
    logic        irq;

    typedef struct {
        logic [31:0] exp;
        bit          is_irq;
        string       req;
    } item_t;

    item_t q[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sw_port #(.NSW(NSW), .BASE(BASE), .CYC_PER_MS(4), .STABLE_MS(10)) i_sw_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sw_raw(sw_raw), .irq(irq)
    );

    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] got;
                it = q.pop_front();
                got = it.is_irq ? {31'b0, irq} : bus_rdata;
                n_chk++;
                if (got !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", it.req, got, it.exp);
                end
            end
        end
    end

    task automatic rd(input logic [31:0] a, input logic [31:0] e, input string req);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        q.push_back('{exp: e, is_irq: 1'b0, req: req});
        @(negedge clk);
        bus_addr = A_IDLE;
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        q.push_back('{exp: 32'h0, is_irq: 1'b0, req: "R9 rdata during write"});
        @(negedge clk);
        bus_addr = A_IDLE; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic chk_irq(input logic e, input string req);
        @(negedge clk);
        q.push_back('{exp: {31'b0, e}, is_irq: 1'b1, req: req});
    endtask

    task automatic set_sw(input logic [NSW-1:0] v);
        @(negedge clk);
        sw_raw = v;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        rst = 1'b0;
        // R1 reset state
        rd(A_CTRL, 32'h0, "R1 ctrl after reset");
        rd(A_DATA, 32'h0, "R1 data after reset");
        chk_irq(1'b0, "R1 irq after reset");

        // R2 short glitch ignored
        set_sw(10'h001);
        wait_cyc(20);
        set_sw(10'h000);
        wait_cyc(60);
        rd(A_DATA, 32'h0, "R2 glitch data");
        rd(A_CTRL, 32'h0, "R2 glitch ready");

        // R2/R3 real change
        set_sw(10'h2A5);
        wait_cyc(25);
        rd(A_DATA, 32'h0, "R2 mid-window data");
        wait_cyc(50);
        rd(A_CTRL, 32'h1, "R3 ready after change");
        rd(A_DATA, 32'h2A5, "R2 new data");
        rd(A_CTRL, 32'h0, "R4 ready cleared by read");

        // R7 interrupt enable
        wr(A_CTRL, 32'h100);
        rd(A_CTRL, 32'h100, "R7 ie readback");
        chk_irq(1'b0, "R7 irq with ready low");
        set_sw(10'h155);
        wait_cyc(60);
        chk_irq(1'b1, "R7 irq with ready and ie");
        rd(A_CTRL, 32'h101, "R3 ready with ie");

        // R5 overrun
        set_sw(10'h3FF);
        wait_cyc(60);
        rd(A_CTRL, 32'h105, "R5 overrun set");
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, 32'h105, "R6 write ones keeps overrun");
        wr(A_CTRL, 32'h104);
        rd(A_CTRL, 32'h105, "R6 ready bit write ignored");
        wr(A_CTRL, 32'h000);
        rd(A_CTRL, 32'h001, "R6 overrun cleared by zero");
        chk_irq(1'b0, "R7 irq after ie cleared");
        rd(A_DATA, 32'h3FF, "R2 data after second change");
        rd(A_CTRL, 32'h000, "R4 ready cleared again");

        // R8 data writes ignored
        wr(A_DATA, 32'h0000_0ABC);
        rd(A_DATA, 32'h3FF, "R8 data unchanged by write");
        rd(A_CTRL, 32'h000, "R8 flags unchanged by write");

        // R9 bus quiet when not addressed
        set_sw(10'h00F);
        wait_cyc(60);
        rd(A_OTHER, 32'h0, "R9 unaddressed read");
        rd(A_CTRL, 32'h001, "R3 ready before unaddressed check");
        rd(A_DATA, 32'h00F, "R9 data upper bits zero");

        wait_cyc(3);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule